// File: doc/BRIEF.md
# Multiprocessor Address Filter for a 9-bit Serial Receiver

This block sits after a 9-bit serial receiver, in front of the receive buffer of a small serial port. When the receiver reports a finished frame, the filter decides whether the frame is stored and whether the receive-complete flag is raised. In multiprocessor operation, a frame whose ninth bit is clear is dropped. A frame whose ninth bit is set is kept only when it matches either the node's own masked address or the broadcast address formed from the same two registers.

The block also holds the receive-complete and transmit-complete flags. Software clears these flags; hardware only sets them. The block combines the two flags into one interrupt request, which reaches the output only when two enable bits are set. The receiver provides two strobes: one at the ninth-bit sample and one at the stop-bit sample. The frame-error-detection input and the mode select which strobe counts.

Registers are written through a small address/data/write-enable port. Bit sampling, baud generation and the transmitter are outside this block.

Top module: `mpaf_top`

## Requirements
- R1: After reset, `rx_flag`, `tx_flag` and `irq` are 0 and `rx_buf` is 00h.
- R2: After reset, the node address register (reg_addr 0) and the mask register (reg_addr 1) both hold 00h. In multiprocessor mode every frame with a set ninth bit is then accepted, whatever its data value.
- R3: Own-address match: at every bit where the mask is 1, the frame bit must equal the node address bit. Bits where the mask is 0 are ignored. For example, address 56h with mask FCh accepts 54h and 57h and rejects 5Eh.
- R4: Broadcast match: the broadcast pattern is (address OR mask). Every 1 bit of the pattern must be 1 in the frame, and 0 bits are don't-care. Examples: (F1h,FAh), (F3h,F9h) and (F2h,FDh) all accept FFh. Only the first two of them accept FBh.
- R5: Multiprocessor mode is active when control bit 0 (nine-bit mode) and control bit 1 (multiprocessor enable) are both 1. In this mode a frame with ninth bit 0 leaves both `rx_buf` and `rx_flag` unchanged.
- R6: Outside multiprocessor mode, every frame is accepted regardless of its address and ninth bit.
- R7: An accepted frame loads `rx_buf` and sets `rx_flag` on the same clock edge, which is the edge that samples the strobe.
- R8: In nine-bit mode with frame-error detection off, only `bit9_stb` delivers frames. In every other setting, only `stop_stb` delivers frames. The other strobe has no effect.
- R9: `rx_flag` and `tx_flag` stay set until cleared through `flag_clr` (bit 0 clears receive, bit 1 clears transmit).
- R10: When a clear and a hardware set happen in the same cycle, the set wins. A clear in a later cycle drops the flag.
- R11: `irq` is (`rx_flag` OR `tx_flag`) AND control bit 2 (port enable) AND control bit 3 (global enable).
- R12: A `tx_done` pulse sets `tx_flag` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 address, 1 mask, 2 control |
| reg_wdata | input | 8 | Register write data |
| frame_data | input | 8 | Received data byte |
| frame_bit9 | input | 1 | Received ninth bit |
| bit9_stb | input | 1 | Strobe at the ninth-bit sample |
| stop_stb | input | 1 | Strobe at the stop-bit sample |
| fe_det_en | input | 1 | Frame-error detection enabled |
| tx_done | input | 1 | Transmit-complete pulse |
| flag_clr | input | 2 | Software flag clear: bit 0 receive, bit 1 transmit |
| rx_buf | output | 8 | Receive buffer |
| rx_flag | output | 1 | Receive-complete flag |
| tx_flag | output | 1 | Transmit-complete flag |
| irq | output | 1 | Combined serial interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit address, broadcast matching enabled and a 2-bit register select. This is the only setting in which the three-node broadcast example and the 56h/FCh own-address cases apply bit for bit. With broadcast matching on, the table can tell frames accepted only through the OR-formed pattern (FEh against 56h/FCh) apart from frames accepted through the masked own address. Every strobe/mode pairing is reachable through the control register and `fe_det_en`.

// File: rtl/mpaf_pkg.sv
package mpaf_pkg;

   typedef enum logic [1:0] {
      SEL_NODE_ADR = 2'd0,
      SEL_ADR_MASK = 2'd1,
      SEL_CTRL     = 2'd2
   } reg_sel_e;

   // control register layout, bit 0 upward
   typedef struct packed {
      logic glob_ie;    // bit 3
      logic port_ie;    // bit 2
      logic mp_en;      // bit 1
      logic nine_mode;  // bit 0
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mpaf_regs.sv
module mpaf_regs
   import mpaf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] node_adr,
   output logic [DATA_W-1:0] adr_mask,
   output ctrl_t             ctrl
);

   localparam logic [SEL_W-1:0] S_ADR  = SEL_W'(SEL_NODE_ADR);
   localparam logic [SEL_W-1:0] S_MASK = SEL_W'(SEL_ADR_MASK);
   localparam logic [SEL_W-1:0] S_CTRL = SEL_W'(SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         node_adr <= '0;
         adr_mask <= '0;
         ctrl     <= '0;
      end else if (we) begin
         if (sel == S_ADR)  node_adr <= wdata;
         if (sel == S_MASK) adr_mask <= wdata;
         if (sel == S_CTRL) ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

endmodule

// File: rtl/mpaf_match.sv
module mpaf_match #(
   parameter int DATA_W   = 8,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic [DATA_W-1:0] frame,
   input  logic [DATA_W-1:0] node_adr,
   input  logic [DATA_W-1:0] adr_mask,
   output logic              own_hit,
   output logic              bcast_hit
);

   logic [DATA_W-1:0] own_ok;
   logic [DATA_W-1:0] bc_ok;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      // masked-off bit, or equal to the node address
      assign own_ok[b] = !adr_mask[b] || (frame[b] == node_adr[b]);
      // pattern bit clear (don't care), or frame bit is one
      assign bc_ok[b]  = !(node_adr[b] || adr_mask[b]) || frame[b];
   end

   assign own_hit = &own_ok;

   if (BCAST_EN) begin : g_bcast
      assign bcast_hit = &bc_ok;
   end else begin : g_no_bcast
      logic unused_bc;
      assign unused_bc = &bc_ok;
      assign bcast_hit = 1'b0;
   end

endmodule

// File: rtl/mpaf_flags.sv
module mpaf_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_set,
   input  logic       tx_set,
   input  logic [1:0] clr,
   input  logic       port_ie,
   input  logic       glob_ie,
   output logic       rx_flag,
   output logic       tx_flag,
   output logic       irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_flag <= 1'b0;
         tx_flag <= 1'b0;
      end else begin
         // a hardware set outranks a clear in the same cycle
         if (rx_set)      rx_flag <= 1'b1;
         else if (clr[0]) rx_flag <= 1'b0;
         if (tx_set)      tx_flag <= 1'b1;
         else if (clr[1]) tx_flag <= 1'b0;
      end
   end

   assign irq = (rx_flag || tx_flag) && port_ie && glob_ie;

endmodule

// File: rtl/mpaf_top.sv
module mpaf_top
   import mpaf_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEL_W    = 2,
   parameter bit BCAST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [SEL_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] frame_data,
   input  logic              frame_bit9,
   input  logic              bit9_stb,
   input  logic              stop_stb,
   input  logic              fe_det_en,
   input  logic              tx_done,
   input  logic [1:0]        flag_clr,
   output logic [DATA_W-1:0] rx_buf,
   output logic              rx_flag,
   output logic              tx_flag,
   output logic              irq
);

   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("mpaf_top: DATA_W must hold the control field");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("mpaf_top: SEL_W must be at least 2");
   end

   logic [DATA_W-1:0] node_adr;
   logic [DATA_W-1:0] adr_mask;
   ctrl_t             ctrl;
   logic              own_hit;
   logic              bcast_hit;
   logic              sel_stb;
   logic              mp_active;
   logic              accept;

   mpaf_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .sel      (reg_addr),
      .wdata    (reg_wdata),
      .node_adr (node_adr),
      .adr_mask (adr_mask),
      .ctrl     (ctrl)
   );

   mpaf_match #(.DATA_W(DATA_W), .BCAST_EN(BCAST_EN)) u_match (
      .frame     (frame_data),
      .node_adr  (node_adr),
      .adr_mask  (adr_mask),
      .own_hit   (own_hit),
      .bcast_hit (bcast_hit)
   );

   // ninth-bit timing only when nine-bit mode runs without error detection
   assign sel_stb   = (ctrl.nine_mode && !fe_det_en) ? bit9_stb : stop_stb;
   assign mp_active = ctrl.nine_mode && ctrl.mp_en;
   assign accept    = sel_stb &&
                      (!mp_active || (frame_bit9 && (own_hit || bcast_hit)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rx_buf <= '0;
      else if (accept) rx_buf <= frame_data;
   end

   mpaf_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_set  (accept),
      .tx_set  (tx_done),
      .clr     (flag_clr),
      .port_ie (ctrl.port_ie),
      .glob_ie (ctrl.glob_ie),
      .rx_flag (rx_flag),
      .tx_flag (tx_flag),
      .irq     (irq)
   );

endmodule

// File: rtl/mpaf_chk.sv
module mpaf_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] rx_buf,
   input logic              rx_flag,
   input logic              tx_flag,
   input logic              irq,
   input logic              tx_done,
   input logic [1:0]        flag_clr,
   input logic              sel_stb,
   input logic              mp_active,
   input logic              frame_bit9
);

   // R9: receive flag only falls after a clear request
   a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_flag) |-> $past(flag_clr[0]));

   // R9: transmit flag only falls after a clear request
   a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_flag) |-> $past(flag_clr[1]));

   // R7: buffer changes always come with the receive flag set
   a_r7_buf_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_buf) |-> rx_flag);

   // R12, R10: transmit pulse sets the flag, even against a clear
   a_r12_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> tx_flag);

   // R5: dropped frames in multiprocessor mode leave the buffer alone
   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_stb && mp_active && !frame_bit9) |=> $stable(rx_buf));

   // R8: no selected strobe, no buffer change
   a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_stb |=> $stable(rx_buf));

   // R11: request needs a pending flag
   a_r11_irq_src: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rx_flag || tx_flag));

endmodule

bind mpaf_top mpaf_chk #(.DATA_W(DATA_W)) u_mpaf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_buf     (rx_buf),
   .rx_flag    (rx_flag),
   .tx_flag    (tx_flag),
   .irq        (irq),
   .tx_done    (tx_done),
   .flag_clr   (flag_clr),
   .sel_stb    (sel_stb),
   .mp_active  (mp_active),
   .frame_bit9 (frame_bit9)
);

// File: tb/mpaf_top_tb.sv
module mpaf_top_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] frame_data = '0;
   logic       frame_bit9 = 1'b0;
   logic       bit9_stb = 1'b0;
   logic       stop_stb = 1'b0;
   logic       fe_det_en = 1'b0;
   logic       tx_done = 1'b0;
   logic [1:0] flag_clr = '0;
   logic [7:0] rx_buf;
   logic       rx_flag;
   logic       tx_flag;
   logic       irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_buf = 8'h00;

   always #10 clk = ~clk;

   mpaf_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .frame_data(frame_data), .frame_bit9(frame_bit9),
      .bit9_stb(bit9_stb), .stop_stb(stop_stb), .fe_det_en(fe_det_en),
      .tx_done(tx_done), .flag_clr(flag_clr), .rx_buf(rx_buf),
      .rx_flag(rx_flag), .tx_flag(tx_flag), .irq(irq)
   );

   // {node_adr, mask, frame, bit9, expect_accept}
   localparam logic [25:0] VEC [0:11] = '{
      {8'hF1, 8'hFA, 8'hFF, 1'b1, 1'b1},
      {8'hF3, 8'hF9, 8'hFF, 1'b1, 1'b1},
      {8'hF2, 8'hFD, 8'hFF, 1'b1, 1'b1},
      {8'hF1, 8'hFA, 8'hFB, 1'b1, 1'b1},
      {8'hF3, 8'hF9, 8'hFB, 1'b1, 1'b1},
      {8'hF2, 8'hFD, 8'hFB, 1'b1, 1'b0},
      {8'h56, 8'hFC, 8'h54, 1'b1, 1'b1},
      {8'h56, 8'hFC, 8'h57, 1'b1, 1'b1},
      {8'h56, 8'hFC, 8'h5E, 1'b1, 1'b0},
      {8'h56, 8'hFC, 8'hFE, 1'b1, 1'b1},
      {8'h00, 8'h00, 8'hA5, 1'b1, 1'b1},
      {8'h56, 8'hFC, 8'h54, 1'b0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic clr(input logic [1:0] m);
      @(negedge clk); flag_clr = m;
      @(negedge clk); flag_clr = '0;
   endtask

   // one-cycle strobe; returns at the negedge after the sampling edge
   task automatic frame(input logic use_stop, input logic [7:0] d, input logic b9);
      @(negedge clk); frame_data = d; frame_bit9 = b9;
      if (use_stop) stop_stb = 1'b1; else bit9_stb = 1'b1;
      @(negedge clk); stop_stb = 1'b0; bit9_stb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      check("R1 rx_flag", rx_flag, 0);
      check("R1 tx_flag", tx_flag, 0);
      check("R1 irq", irq, 0);
      check("R1 rx_buf", rx_buf, 0);

      // R2: only control written; address and mask still at reset
      wr(2'd2, 8'h03);
      frame(1'b0, 8'h3C, 1'b1);
      exp_buf = 8'h3C;
      check("R2 rx_flag", rx_flag, 1);
      check("R2 rx_buf", rx_buf, exp_buf);

      // R3 R4 R5 R7: table walk in multiprocessor mode
      foreach (VEC[i]) begin
         wr(2'd0, VEC[i][25:18]);
         wr(2'd1, VEC[i][17:10]);
         clr(2'b01);
         frame(1'b0, VEC[i][9:2], VEC[i][1]);
         if (VEC[i][0]) exp_buf = VEC[i][9:2];
         check($sformatf("R3/R4/R5/R7 vec%0d flag", i), rx_flag, VEC[i][0]);
         check($sformatf("R3/R4/R5/R7 vec%0d buf", i), rx_buf, exp_buf);
      end

      // R6: nine-bit mode without multiprocessor enable takes everything
      wr(2'd2, 8'h01);
      clr(2'b01);
      frame(1'b0, 8'h11, 1'b0);
      exp_buf = 8'h11;
      check("R6 flag", rx_flag, 1);
      check("R6 buf", rx_buf, exp_buf);

      // R8: error detection on -> ninth-bit strobe ignored, stop strobe used
      fe_det_en = 1'b1;
      clr(2'b01);
      frame(1'b0, 8'h22, 1'b1);
      check("R8 bit9 ignored flag", rx_flag, 0);
      check("R8 bit9 ignored buf", rx_buf, exp_buf);
      frame(1'b1, 8'h22, 1'b1);
      exp_buf = 8'h22;
      check("R8 stop flag", rx_flag, 1);
      check("R8 stop buf", rx_buf, exp_buf);
      // R8: eight-bit mode, detection off -> stop strobe only
      fe_det_en = 1'b0;
      wr(2'd2, 8'h00);
      clr(2'b01);
      frame(1'b0, 8'h33, 1'b0);
      check("R8 8bit bit9 ignored", rx_buf, exp_buf);
      frame(1'b1, 8'h33, 1'b0);
      exp_buf = 8'h33;
      check("R8 8bit stop buf", rx_buf, exp_buf);

      // R9: flag persists
      repeat (5) @(negedge clk);
      check("R9 rx sticky", rx_flag, 1);

      // R10: same-cycle clear loses, later clear wins
      @(negedge clk); frame_data = 8'h44; stop_stb = 1'b1; flag_clr = 2'b01;
      @(negedge clk); stop_stb = 1'b0; flag_clr = 2'b00;
      exp_buf = 8'h44;
      check("R10 set wins", rx_flag, 1);
      check("R10 buf", rx_buf, exp_buf);
      clr(2'b01);
      check("R10 later clear", rx_flag, 0);

      // R12 and R11
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
      check("R12 tx_flag", tx_flag, 1);
      check("R11 irq no enables", irq, 0);
      wr(2'd2, 8'h04);
      check("R11 irq port only", irq, 0);
      wr(2'd2, 8'h08);
      check("R11 irq global only", irq, 0);
      wr(2'd2, 8'h0C);
      check("R11 irq both", irq, 1);
      clr(2'b10);
      check("R9 tx cleared", tx_flag, 0);
      check("R11 irq idle", irq, 0);
      frame(1'b1, 8'h55, 1'b0);
      check("R11 irq from rx", irq, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule